// File: doc/BRIEF.md
# Per-Bank State Tracker for One Memory Rank

This block keeps, for every bank of one memory rank, a small record of what the command stream has done to it. The record holds whether a row is open and which one, whether the bank is asleep in a low-power state, and whether the refresh scheduler has held it back from normal traffic. Each command that the controller issues is shown to the block once. It carries an opcode, a rank, a bank and a row. The block works out which banks the command touches and updates those banks on the next clock edge.

A command can reach its banks in three ways. Rank-wide commands touch every bank. Single-bank commands touch only the bank they address. Same-slot commands touch one bank in every bank group: the bank whose index inside its group matches the index of the addressed bank. With G banks per group, a same-slot command addressed to bank b reaches banks b mod G, b mod G + G, b mod G + 2G and so on, up to the number of banks.

The refresh scheduler can also hold back any bank directly through a per-bank input. Each bank reports idle when it has no pending request and is not held back. All outputs are registered.

Top module: `bank_state_array`

## Requirements
- R1: While reset is high, and on the first edge after reset, every bank reports closed, row 0, not asleep, not blocked and not idle.
- R2: Opcode 1 (open) addressed to bank b of this rank marks bank b open and stores cmd_row as its row, visible after the next clock edge; no other bank changes.
- R3: Opcode 2 (close one) marks only the addressed bank closed and keeps its stored row.
- R4: Opcodes 4 (close same slot) and 9 (refresh same slot) act on every bank i with i mod BANKS_PER_GROUP equal to cmd_bank mod BANKS_PER_GROUP. This holds for any bank code, including codes at or above the bank count.
- R5: Opcodes 3 (close all), 7 (refresh all), 10 (power-down with rows open), 11 (power-down with rows closed) and 12 (self-refresh entry) act on every bank regardless of cmd_bank.
- R6: The refresh opcodes 7, 8 (refresh one) and 9 clear both the asleep flag and the blocked flag of each bank they reach. They leave the open state and the row unchanged.
- R7: Opcodes 10, 11 and 12 set the asleep flag of every bank and leave the open state and the row unchanged.
- R8: A high blk_set[i] sets the blocked flag of bank i. The flag stays set until a refresh reaches bank i. If blk_set[i] and a refresh reaching bank i occur in the same cycle, blk_set wins.
- R9: bank_idle[i] after an edge equals the inverse of req_pending[i] sampled at that edge, ANDed with the inverse of the blocked flag after that edge.
- R10: A command with cmd_valid low, or with cmd_rank different from RANK_ID, or with opcode 0, 5, 6 or 13 to 15, changes nothing. The same holds for a single-bank opcode whose bank code is at or above the bank count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_rank | input | RANK_W | Rank the command targets |
| cmd_bank | input | BANK_W | Bank the command addresses |
| cmd_row | input | ROW_W | Row carried by an open command |
| req_pending | input | NUM_BANKS | Per-bank: a request waits for this bank |
| blk_set | input | NUM_BANKS | Per-bank: refresh scheduler holds the bank back |
| bank_open | output | NUM_BANKS | Per-bank: a row is open |
| bank_row | output | NUM_BANKS*ROW_W | Per-bank stored row, bank 0 in the low bits |
| bank_sleep | output | NUM_BANKS | Per-bank: asleep in a low-power state |
| bank_blocked | output | NUM_BANKS | Per-bank: held back until refreshed |
| bank_idle | output | NUM_BANKS | Per-bank: no pending request and not blocked |

## Verification
The bench builds the block with six banks in groups of two, a 3-bit bank code, a 4-bit row and a 2-bit rank field with RANK_ID 1. With these values every opcode, all eight bank codes (two of them beyond the last bank) and both a matching and a foreign rank can be swept in full. The out-of-range codes show that single-bank commands drop them while same-slot commands still reduce them modulo the group size. Before each swept command a preparation command opens a bank, and the blocked and pending patterns rotate, so each opcode meets banks in mixed states.

// File: rtl/bst_pkg.sv
package bst_pkg;

  localparam logic [3:0] OP_NOP        = 4'd0;
  localparam logic [3:0] OP_OPEN       = 4'd1;
  localparam logic [3:0] OP_CLOSE      = 4'd2;
  localparam logic [3:0] OP_CLOSE_ALL  = 4'd3;
  localparam logic [3:0] OP_CLOSE_SLOT = 4'd4;
  localparam logic [3:0] OP_READ       = 4'd5;
  localparam logic [3:0] OP_WRITE      = 4'd6;
  localparam logic [3:0] OP_REF_ALL    = 4'd7;
  localparam logic [3:0] OP_REF_ONE    = 4'd8;
  localparam logic [3:0] OP_REF_SLOT   = 4'd9;
  localparam logic [3:0] OP_PD_OPEN    = 4'd10;
  localparam logic [3:0] OP_PD_CLOSED  = 4'd11;
  localparam logic [3:0] OP_SR_ENTER   = 4'd12;

  typedef enum logic [1:0] {
    SC_NONE  = 2'd0,
    SC_BANK  = 2'd1,
    SC_SLOT  = 2'd2,
    SC_RANK  = 2'd3
  } scope_e;

  typedef struct packed {
    logic open;
    logic close;
    logic wake;
    logic sleep;
  } effect_t;

endpackage

// File: rtl/bst_cmd_decode.sv
module bst_cmd_decode
  import bst_pkg::*;
(
  input  logic [3:0] op,
  output scope_e     scope,
  output effect_t    eff
);

  always_comb begin
    scope = SC_NONE;
    eff   = '0;
    unique case (op)
      OP_OPEN:       begin scope = SC_BANK; eff.open  = 1'b1; end
      OP_CLOSE:      begin scope = SC_BANK; eff.close = 1'b1; end
      OP_CLOSE_ALL:  begin scope = SC_RANK; eff.close = 1'b1; end
      OP_CLOSE_SLOT: begin scope = SC_SLOT; eff.close = 1'b1; end
      OP_REF_ALL:    begin scope = SC_RANK; eff.wake  = 1'b1; end
      OP_REF_ONE:    begin scope = SC_BANK; eff.wake  = 1'b1; end
      OP_REF_SLOT:   begin scope = SC_SLOT; eff.wake  = 1'b1; end
      OP_PD_OPEN,
      OP_PD_CLOSED,
      OP_SR_ENTER:   begin scope = SC_RANK; eff.sleep = 1'b1; end
      default:       begin scope = SC_NONE; eff = '0; end
    endcase
  end

endmodule

// File: rtl/bst_target_mask.sv
module bst_target_mask
  import bst_pkg::*;
#(
  parameter int NUM_BANKS       = 16,
  parameter int BANKS_PER_GROUP = 4,
  parameter int RANK_W          = 2,
  parameter int RANK_ID         = 0,
  localparam int BANK_W         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 valid,
  input  scope_e               scope,
  input  logic [RANK_W-1:0]    rank,
  input  logic [BANK_W-1:0]    bank,
  output logic [NUM_BANKS-1:0] hit
);

  localparam logic [RANK_W-1:0] MY_RANK = RANK_W'(RANK_ID);

  logic rank_ok;
  int   bank_num;
  int   slot_num;

  assign rank_ok  = valid && (rank == MY_RANK);
  assign bank_num = int'(bank);
  assign slot_num = bank_num % BANKS_PER_GROUP;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_sel
    localparam int SLOT = i % BANKS_PER_GROUP;
    always_comb begin
      unique case (scope)
        SC_BANK: hit[i] = rank_ok && (bank_num == i);
        SC_SLOT: hit[i] = rank_ok && (slot_num == SLOT);
        SC_RANK: hit[i] = rank_ok;
        default: hit[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/bst_bank_slot.sv
module bst_bank_slot
  import bst_pkg::*;
#(
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  effect_t          eff,
  input  logic [ROW_W-1:0] row_in,
  input  logic             blk_req,
  input  logic             pending,
  output logic             open_q,
  output logic [ROW_W-1:0] row_q,
  output logic             sleep_q,
  output logic             blk_q,
  output logic             idle_q
);

  logic blk_n;
  logic sleep_n;
  logic open_n;

  always_comb begin
    open_n = open_q;
    if (hit && eff.open)  open_n = 1'b1;
    if (hit && eff.close) open_n = 1'b0;
  end

  always_comb begin
    sleep_n = sleep_q;
    if (hit && eff.sleep) sleep_n = 1'b1;
    if (hit && eff.wake)  sleep_n = 1'b0;
  end

  // the scheduler's hold request takes precedence over a clearing refresh
  always_comb begin
    blk_n = blk_q;
    if (hit && eff.wake) blk_n = 1'b0;
    if (blk_req)         blk_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      sleep_q <= 1'b0;
      blk_q   <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      open_q  <= open_n;
      sleep_q <= sleep_n;
      blk_q   <= blk_n;
      idle_q  <= !pending && !blk_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   row_q <= '0;
    else if (hit && eff.open)  row_q <= row_in;
  end

endmodule

// File: rtl/bank_state_array.sv
module bank_state_array
  import bst_pkg::*;
#(
  parameter int NUM_BANKS       = 16,
  parameter int BANKS_PER_GROUP = 4,
  parameter int ROW_W           = 16,
  parameter int RANK_W          = 2,
  parameter int RANK_ID         = 0,
  localparam int BANK_W         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_valid,
  input  logic [3:0]                 cmd_op,
  input  logic [RANK_W-1:0]          cmd_rank,
  input  logic [BANK_W-1:0]          cmd_bank,
  input  logic [ROW_W-1:0]           cmd_row,
  input  logic [NUM_BANKS-1:0]       req_pending,
  input  logic [NUM_BANKS-1:0]       blk_set,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row,
  output logic [NUM_BANKS-1:0]       bank_sleep,
  output logic [NUM_BANKS-1:0]       bank_blocked,
  output logic [NUM_BANKS-1:0]       bank_idle
);

  scope_e               scope;
  effect_t              eff;
  logic [NUM_BANKS-1:0] hit;

  bst_cmd_decode u_dec (
    .op    (cmd_op),
    .scope (scope),
    .eff   (eff)
  );

  bst_target_mask #(
    .NUM_BANKS       (NUM_BANKS),
    .BANKS_PER_GROUP (BANKS_PER_GROUP),
    .RANK_W          (RANK_W),
    .RANK_ID         (RANK_ID)
  ) u_mask (
    .valid (cmd_valid),
    .scope (scope),
    .rank  (cmd_rank),
    .bank  (cmd_bank),
    .hit   (hit)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    bst_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit[i]),
      .eff     (eff),
      .row_in  (cmd_row),
      .blk_req (blk_set[i]),
      .pending (req_pending[i]),
      .open_q  (bank_open[i]),
      .row_q   (bank_row[i*ROW_W +: ROW_W]),
      .sleep_q (bank_sleep[i]),
      .blk_q   (bank_blocked[i]),
      .idle_q  (bank_idle[i])
    );
  end

endmodule

// File: rtl/bank_state_array_chk.sv
module bank_state_array_chk
  import bst_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int ROW_W     = 16,
  parameter int RANK_W    = 2,
  parameter int RANK_ID   = 0,
  parameter int BANK_W    = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cmd_valid,
  input logic [3:0]                 cmd_op,
  input logic [RANK_W-1:0]          cmd_rank,
  input logic [BANK_W-1:0]          cmd_bank,
  input logic [ROW_W-1:0]           cmd_row,
  input logic [NUM_BANKS-1:0]       req_pending,
  input logic [NUM_BANKS-1:0]       blk_set,
  input logic [NUM_BANKS-1:0]       bank_open,
  input logic [NUM_BANKS*ROW_W-1:0] bank_row,
  input logic [NUM_BANKS-1:0]       bank_sleep,
  input logic [NUM_BANKS-1:0]       bank_blocked,
  input logic [NUM_BANKS-1:0]       bank_idle
);

  logic mine;
  assign mine = cmd_valid && (cmd_rank == RANK_W'(RANK_ID));

  // R5
  a_r5_close_all: assert property (@(posedge clk) disable iff (rst)
    (mine && cmd_op == OP_CLOSE_ALL) |=> (bank_open == '0));

  // R7
  a_r7_sleep_all: assert property (@(posedge clk) disable iff (rst)
    (mine && (cmd_op == OP_PD_OPEN || cmd_op == OP_PD_CLOSED || cmd_op == OP_SR_ENTER))
    |=> (&bank_sleep));

  // R10
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid && blk_set == '0) |=>
    ($stable(bank_open) && $stable(bank_row) && $stable(bank_sleep) && $stable(bank_blocked)));

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_chk
    // R2
    a_r2_open_latch: assert property (@(posedge clk) disable iff (rst)
      (mine && cmd_op == OP_OPEN && int'(cmd_bank) == i) |=>
      (bank_open[i] && bank_row[i*ROW_W +: ROW_W] == $past(cmd_row)));
    // R3
    a_r3_close_one: assert property (@(posedge clk) disable iff (rst)
      (mine && cmd_op == OP_CLOSE && int'(cmd_bank) == i) |=> !bank_open[i]);
    // R8
    a_r8_block_set: assert property (@(posedge clk) disable iff (rst)
      blk_set[i] |=> bank_blocked[i]);
    // R9
    a_r9_idle_rule: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (bank_idle[i] == (!$past(req_pending[i]) && !bank_blocked[i])));
  end

endmodule

bind bank_state_array bank_state_array_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ROW_W     (ROW_W),
  .RANK_W    (RANK_W),
  .RANK_ID   (RANK_ID),
  .BANK_W    (BANK_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_valid    (cmd_valid),
  .cmd_op       (cmd_op),
  .cmd_rank     (cmd_rank),
  .cmd_bank     (cmd_bank),
  .cmd_row      (cmd_row),
  .req_pending  (req_pending),
  .blk_set      (blk_set),
  .bank_open    (bank_open),
  .bank_row     (bank_row),
  .bank_sleep   (bank_sleep),
  .bank_blocked (bank_blocked),
  .bank_idle    (bank_idle)
);

// File: tb/sim_bank_state_array.sv
`timescale 1ns/1ps
module sim_bank_state_array;

  localparam int NB  = 6;
  localparam int G   = 2;
  localparam int RW  = 4;
  localparam int KW  = 2;
  localparam int RID = 1;
  localparam int BW  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [3:0]    cmd_op = '0;
  logic [KW-1:0] cmd_rank = '0;
  logic [BW-1:0] cmd_bank = '0;
  logic [RW-1:0] cmd_row = '0;
  logic [NB-1:0] req_pending = '0;
  logic [NB-1:0] blk_set = '0;
  logic [NB-1:0] bank_open, bank_sleep, bank_blocked, bank_idle;
  logic [NB*RW-1:0] bank_row;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bank_state_array #(
    .NUM_BANKS(NB), .BANKS_PER_GROUP(G), .ROW_W(RW), .RANK_W(KW), .RANK_ID(RID)
  ) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_rank(cmd_rank),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .req_pending(req_pending), .blk_set(blk_set),
    .bank_open(bank_open), .bank_row(bank_row), .bank_sleep(bank_sleep),
    .bank_blocked(bank_blocked), .bank_idle(bank_idle)
  );

  // reference state derived from the requirements
  logic [NB-1:0]    m_open = '0, m_sleep = '0, m_blk = '0, m_idle = '0;
  logic [NB*RW-1:0] m_row = '0;

  function automatic bit reaches(int op, int rank, int bank, int i);
    if (rank != RID) return 0;
    case (op)
      1, 2, 8:          return bank == i;        // single bank
      4, 9:             return (bank % G) == (i % G); // same slot
      3, 7, 10, 11, 12: return 1;                // whole rank
      default:          return 0;
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string open_tag(int op);
    case (op)
      1: return "R2";
      2: return "R3";
      4, 9: return "R4";
      3, 7, 10, 11, 12: return "R5";
      default: return "R10";
    endcase
  endfunction

  function automatic string sleep_tag(int op);
    case (op)
      7, 8, 9: return "R6";
      10, 11, 12: return "R7";
      default: return "R10";
    endcase
  endfunction

  // one command cycle: drive at a falling edge, update the model at the
  // rising edge, compare at the following falling edge
  task automatic step(int op, int rank, int bank, int row, logic [NB-1:0] blk, logic [NB-1:0] pend);
    cmd_valid   = 1'b1;
    cmd_op      = 4'(op);
    cmd_rank    = KW'(rank);
    cmd_bank    = BW'(bank);
    cmd_row     = RW'(row);
    blk_set     = blk;
    req_pending = pend;
    @(posedge clk);
    for (int i = 0; i < NB; i++) begin
      if (reaches(op, rank, bank, i)) begin
        if (op == 1) begin m_open[i] = 1'b1; m_row[i*RW +: RW] = RW'(row); end
        if (op == 2 || op == 3 || op == 4) m_open[i] = 1'b0;
        if (op == 7 || op == 8 || op == 9) begin m_sleep[i] = 1'b0; m_blk[i] = 1'b0; end
        if (op >= 10 && op <= 12) m_sleep[i] = 1'b1;
      end
      if (blk[i]) m_blk[i] = 1'b1;
      m_idle[i] = !pend[i] && !m_blk[i];
    end
    @(negedge clk);
    check(open_tag(op), 64'(bank_open), 64'(m_open));
    check("R2 row", 64'(bank_row), 64'(m_row));
    check(sleep_tag(op), 64'(bank_sleep), 64'(m_sleep));
    check("R8", 64'(bank_blocked), 64'(m_blk));
    check("R9", 64'(bank_idle), 64'(m_idle));
    cmd_valid = 1'b0;
    blk_set   = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check("R1 open", 64'(bank_open), 64'd0);
    check("R1 row", 64'(bank_row), 64'd0);
    check("R1 sleep", 64'(bank_sleep), 64'd0);
    check("R1 blocked", 64'(bank_blocked), 64'd0);
    check("R1 idle", 64'(bank_idle), 64'd0);
    rst = 1'b0;

    // R8: hold request beats a same-cycle refresh
    step(7, RID, 0, 0, 6'b000001, '0);
    step(7, RID, 0, 0, 6'b000010, '0);
    check("R8 tie", 64'(bank_blocked[1]), 64'd1);

    // R10: rank mismatch on open leaves everything as it was
    step(1, 0, 2, 9, '0, '0);

    cnt = 0;
    for (int op = 0; op < 16; op++) begin
      for (int bank = 0; bank < 8; bank++) begin
        for (int rsel = 0; rsel < 2; rsel++) begin
          int rank;
          rank = (rsel == 0) ? RID : 2;
          cnt++;
          // preparation: open some bank, vary hold and pending patterns
          step(1, RID, (bank + cnt) % NB, cnt % 16, NB'((cnt * 5) % 64) & 6'b010101, NB'((cnt * 11) % 64));
          if (cnt % 7 == 0) step(10, RID, 0, 0, '0, NB'(cnt % 64));
          step(op, rank, bank, (cnt * 3) % 16, NB'(cnt % 3 == 0 ? 6'b100000 : 6'b0), NB'((cnt * 13) % 64));
        end
      end
    end

    // R4 explicit: same-slot refresh from out-of-range code 7 wakes odd banks
    step(11, RID, 0, 0, '0, '0);
    step(9, RID, 7, 0, '0, '0);
    check("R4 slot", 64'(bank_sleep), 64'(6'b010101));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule